// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Sleep Gating

This block sits after a clock synthesizer. It turns two running clocks, a core clock and a peripheral-bus clock, into groups of gated output clocks. Three active-low controls drive the gating. A core-hold request stops the core group. A bus-hold request stops the stoppable bus group. A sleep request stops everything, including one bus output that is otherwise free-running. A drive-enable bit releases every output to high impedance.

Each control is resynchronized into the domain of the clock it gates. The gate enables are updated only on the falling edge of that clock. An output therefore always stops low and restarts with a full high phase, and never carries a shortened pulse.

The latency is a fixed number of source-clock rising edges, set by the synchronizer depth of each control. Consumers see a stop or restart that is predictable to the edge.

Top module: `clk_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, all outputs are low when `drive_en` is 1. After reset is released with every control high, the core outputs first go high at the third core rising edge. The bus outputs and the free bus output first go high at the third bus rising edge.
- R2: When `core_hold_n` falls between two core rising edges, the core outputs still give full high phases at the next two rising edges and are low from the third rising edge on.
- R3: When `core_hold_n` returns high (sleep inactive), the core outputs stay low for two rising edges and give their first full high phase at the third.
- R4: `bus_hold_n` is sampled by one flop on the bus rising edge. The stoppable bus outputs still pulse at the first bus rising edge after the change and are low from the second.
- R5: When `bus_hold_n` returns high (sleep inactive), the stoppable bus outputs are high again from the second bus rising edge after the change.
- R6: The free bus output keeps toggling whatever the level of `bus_hold_n`.
- R7: When `sleep_n` falls, each domain uses its own two-flop synchronizer. The core outputs are low from the third core rising edge. All bus outputs, the free one included, are low from the third bus rising edge. Every high phase before that point is full.
- R8: When `sleep_n` returns high with both holds inactive, the core and bus outputs resume with a full high phase at the third rising edge of their own clock.
- R9: Sleep overrides the holds. Toggling the holds during sleep leaves every output low. Releasing sleep while the holds are still low restarts only the free bus output.
- R10: When `drive_en` is 0, every output is high impedance at once, whatever the clocks and controls are doing. When it returns to 1, the outputs are driven again with the gated value.
- R11: Every high pulse on a driven output lasts exactly the high phase of its source clock (no runt pulses).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| core_clk | input | 1 | Running core clock |
| bus_clk | input | 1 | Running peripheral-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset of synchronizers and gate enables |
| core_hold_n | input | 1 | Active-low request to stop the core group |
| bus_hold_n | input | 1 | Active-low request to stop the stoppable bus group |
| sleep_n | input | 1 | Active-low sleep request, stops all clock outputs |
| drive_en | input | 1 | Latched output-drive bit; 0 puts all outputs in high impedance |
| core_clk_o | output | N_CORE | Gated core clocks |
| bus_clk_o | output | N_BUS | Gated, stoppable bus clocks |
| bus_clk_free_o | output | 1 | Bus clock gated by sleep only |

## Verification
A wrong synchronizer depth or reset value moves the first low or first high pulse by one source-clock edge. That is visible at the outputs within three or four rising edges of the control change. An enable captured on the wrong edge shows up as a shortened high pulse the first time the enable changes. A broken priority between sleep and the holds shows up as a pulse that appears while sleep is low, or as a free bus output that stays dead after sleep is released. A missing drive-enable override shows up as a driven level where high impedance is expected, in the same cycle.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

  // Rising edge (counted from the control change) at which an output is
  // first affected: the synchronizer stages plus the falling-edge enable.
  function automatic int first_effect_edge(input int stages);
    return stages + 1;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Width of a saturating run-length counter able to exceed max_count.
  function automatic int age_width(input int max_count);
    return $clog2(max_count + 2);
  endfunction

endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/level_age.sv
module level_age #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lvl,
  output logic [W-1:0] lo_cnt,
  output logic [W-1:0] hi_cnt
);
  // Consecutive rising edges at which lvl was sampled low / high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (lvl) begin
      lo_cnt <= '0;
      hi_cnt <= (&hi_cnt) ? hi_cnt : hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      lo_cnt <= (&lo_cnt) ? lo_cnt : lo_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gate_bank.sv
module gate_bank #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic             en,
  output logic [WIDTH-1:0] gclk
);
  // The enable is captured while the clock is low, so every high phase
  // that passes the gate is whole.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= run;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_gate
      assign gclk[i] = clk & en;
    end
  endgenerate

  // R11
  en_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en == run)
    else $error("gate enable not taken from the preceding low phase");
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import clk_gate_pkg::*;
#(
  parameter int N_CORE     = 2,
  parameter int N_BUS      = 5,
  parameter int CORE_SYNC  = 2,
  parameter int BUS_SYNC   = 1,
  parameter int SLEEP_SYNC = 2
) (
  input  logic              core_clk,
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              core_hold_n,
  input  logic              bus_hold_n,
  input  logic              sleep_n,
  input  logic              drive_en,
  output logic [N_CORE-1:0] core_clk_o,
  output logic [N_BUS-1:0]  bus_clk_o,
  output logic              bus_clk_free_o
);
  localparam int MAX_SYNC = max3(CORE_SYNC, BUS_SYNC, SLEEP_SYNC);
  localparam int AGE_W    = age_width(MAX_SYNC);
  localparam int CORE_HIT = first_effect_edge(CORE_SYNC);
  localparam logic [AGE_W-1:0] CORE_A  = AGE_W'(CORE_HIT - 1);
  localparam logic [AGE_W-1:0] BUS_A   = AGE_W'(first_effect_edge(BUS_SYNC) - 1);
  localparam logic [AGE_W-1:0] SLEEP_A = AGE_W'(first_effect_edge(SLEEP_SYNC) - 1);

  // Synchronized controls, one set per gated domain
  logic core_hold_s, core_sleep_s, bus_hold_s, bus_sleep_s;

  gate_sync #(.STAGES(CORE_SYNC)) u_sync_core_hold (
    .clk(core_clk), .rst_n(rst_n), .d(core_hold_n), .q(core_hold_s));
  gate_sync #(.STAGES(SLEEP_SYNC)) u_sync_core_sleep (
    .clk(core_clk), .rst_n(rst_n), .d(sleep_n), .q(core_sleep_s));
  gate_sync #(.STAGES(BUS_SYNC)) u_sync_bus_hold (
    .clk(bus_clk), .rst_n(rst_n), .d(bus_hold_n), .q(bus_hold_s));
  gate_sync #(.STAGES(SLEEP_SYNC)) u_sync_bus_sleep (
    .clk(bus_clk), .rst_n(rst_n), .d(sleep_n), .q(bus_sleep_s));

  // Run requests: sleep wins by AND-ing over every hold
  logic core_run, bus_run, free_run;
  assign core_run = core_hold_s & core_sleep_s;
  assign bus_run  = bus_hold_s & bus_sleep_s;
  assign free_run = bus_sleep_s;

  logic                core_en, bus_en, free_en;
  logic [N_CORE-1:0]   core_gated;
  logic [N_BUS-1:0]    bus_gated;
  logic [0:0]          free_gated;

  gate_bank #(.WIDTH(N_CORE)) u_core_bank (
    .clk(core_clk), .rst_n(rst_n), .run(core_run), .en(core_en), .gclk(core_gated));
  gate_bank #(.WIDTH(N_BUS)) u_bus_bank (
    .clk(bus_clk), .rst_n(rst_n), .run(bus_run), .en(bus_en), .gclk(bus_gated));
  gate_bank #(.WIDTH(1)) u_free_bank (
    .clk(bus_clk), .rst_n(rst_n), .run(free_run), .en(free_en), .gclk(free_gated));

  // Drive-enable overrides everything
  assign core_clk_o     = drive_en ? core_gated    : {N_CORE{1'bz}};
  assign bus_clk_o      = drive_en ? bus_gated     : {N_BUS{1'bz}};
  assign bus_clk_free_o = drive_en ? free_gated[0] : 1'bz;

  // Control run lengths seen by the assertions
  logic [AGE_W-1:0] ch_lo, ch_hi, cs_lo, cs_hi, bh_lo, bh_hi, bs_lo, bs_hi;

  level_age #(.W(AGE_W)) u_age_core_hold (
    .clk(core_clk), .rst_n(rst_n), .lvl(core_hold_n), .lo_cnt(ch_lo), .hi_cnt(ch_hi));
  level_age #(.W(AGE_W)) u_age_core_sleep (
    .clk(core_clk), .rst_n(rst_n), .lvl(sleep_n), .lo_cnt(cs_lo), .hi_cnt(cs_hi));
  level_age #(.W(AGE_W)) u_age_bus_hold (
    .clk(bus_clk), .rst_n(rst_n), .lvl(bus_hold_n), .lo_cnt(bh_lo), .hi_cnt(bh_hi));
  level_age #(.W(AGE_W)) u_age_bus_sleep (
    .clk(bus_clk), .rst_n(rst_n), .lvl(sleep_n), .lo_cnt(bs_lo), .hi_cnt(bs_hi));

  // R2
  core_stop_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
    (ch_lo >= CORE_A) |-> !core_en)
    else $error("core group still enabled after hold latency");

  // R3
  core_start_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
    (ch_hi >= CORE_A && cs_hi >= SLEEP_A) |-> core_en)
    else $error("core group not restarted after release latency");

  // R4
  bus_stop_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (bh_lo >= BUS_A) |-> !bus_en)
    else $error("bus group still enabled one cycle after hold sampled");

  // R5
  bus_start_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (bh_hi >= BUS_A && bs_hi >= SLEEP_A) |-> bus_en)
    else $error("bus group not restarted after hold release");

  // R6
  free_run_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (bs_hi >= SLEEP_A) |-> free_en)
    else $error("free bus output stopped without sleep");

  // R7
  sleep_core_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
    (cs_lo >= SLEEP_A) |-> !core_en)
    else $error("core group running during sleep");

  // R7
  sleep_bus_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (bs_lo >= SLEEP_A) |-> (!bus_en && !free_en))
    else $error("bus outputs running during sleep");
endmodule

// File: tb/clk_gate_ctrl_tb.sv
module clk_gate_ctrl_tb;
  localparam int N_CORE = 2;
  localparam int N_BUS  = 5;

  logic core_clk = 1'b0, bus_clk = 1'b0;
  logic rst_n = 1'b0, core_hold_n = 1'b1, bus_hold_n = 1'b1;
  logic sleep_n = 1'b1, drive_en = 1'b1;
  wire [N_CORE-1:0] core_clk_o;
  wire [N_BUS-1:0]  bus_clk_o;
  wire              bus_clk_free_o;

  clk_gate_ctrl #(.N_CORE(N_CORE), .N_BUS(N_BUS)) u_dut (
    .core_clk(core_clk), .bus_clk(bus_clk), .rst_n(rst_n),
    .core_hold_n(core_hold_n), .bus_hold_n(bus_hold_n), .sleep_n(sleep_n),
    .drive_en(drive_en), .core_clk_o(core_clk_o), .bus_clk_o(bus_clk_o),
    .bus_clk_free_o(bus_clk_free_o));

  always #10 core_clk = ~core_clk;   // 50 MHz core clock
  always #20 bus_clk  = ~bus_clk;    // bus clock at half rate

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  localparam logic [N_CORE-1:0] C1 = '1, C0 = '0, CZ = {N_CORE{1'bz}};
  localparam logic [N_BUS-1:0]  B1 = '1, B0 = '0, BZ = {N_BUS{1'bz}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_core(input string req, input logic [N_CORE-1:0] e);
    chk(req, {{(8-N_CORE){1'b0}}, core_clk_o}, {{(8-N_CORE){1'b0}}, e});
  endtask
  task automatic chk_bus(input string req, input logic [N_BUS-1:0] e, input logic f);
    chk(req, {{(7-N_BUS){1'b0}}, bus_clk_o, bus_clk_free_o},
             {{(7-N_BUS){1'b0}}, e, f});
  endtask

  // sample or drive 5 ns after a rising edge, inside the high phase
  task automatic at_core(input int n);
    repeat (n) @(posedge core_clk);
    #5;
  endtask
  task automatic at_bus(input int n);
    repeat (n) @(posedge bus_clk);
    #5;
  endtask

  // Pulse-width monitor for R11
  bit mon_en = 1'b1;
  int pulses = 0, runts = 0;
  realtime t_c, t_b, t_f;
  bit ok_c, ok_b, ok_f;
  always @(posedge core_clk_o[0]) begin ok_c = mon_en; t_c = $realtime; end
  always @(negedge core_clk_o[0]) begin
    if (mon_en && ok_c) begin pulses++; if ($realtime - t_c != 10.0) runts++; end
    ok_c = 1'b0;
  end
  always @(posedge bus_clk_o[0]) begin ok_b = mon_en; t_b = $realtime; end
  always @(negedge bus_clk_o[0]) begin
    if (mon_en && ok_b) begin pulses++; if ($realtime - t_b != 20.0) runts++; end
    ok_b = 1'b0;
  end
  always @(posedge bus_clk_free_o) begin ok_f = mon_en; t_f = $realtime; end
  always @(negedge bus_clk_free_o) begin
    if (mon_en && ok_f) begin pulses++; if ($realtime - t_f != 20.0) runts++; end
    ok_f = 1'b0;
  end

  task automatic t_reset;
    at_core(3);
    chk_core("R1 core in reset", C0);
    chk_bus("R1 bus in reset", B0, 1'b0);
    rst_n = 1'b1;
    fork
      begin
        at_core(2); chk_core("R1 core edge 2 after reset", C0);
        at_core(1); chk_core("R1 core edge 3 after reset", C1);
      end
      begin
        at_bus(2); chk_bus("R1 bus edge 2 after reset", B0, 1'b0);
        at_bus(1); chk_bus("R1 bus edge 3 after reset", B1, 1'b1);
      end
    join
  endtask

  task automatic t_core_hold;
    at_core(2);
    core_hold_n = 1'b0;
    at_core(1); chk_core("R2 core edge 1", C1);
    at_core(1); chk_core("R2 core edge 2", C1);
    at_core(1); chk_core("R2 core edge 3", C0);
    at_core(1); chk_core("R2 core edge 4", C0);
    core_hold_n = 1'b1;
    at_core(1); chk_core("R3 core edge 1", C0);
    at_core(1); chk_core("R3 core edge 2", C0);
    at_core(1); chk_core("R3 core edge 3", C1);
    at_core(1); chk_core("R3 core edge 4", C1);
  endtask

  task automatic t_bus_hold;
    at_bus(1);
    bus_hold_n = 1'b0;
    at_bus(1); chk_bus("R4 bus edge 1", B1, 1'b1);
    at_bus(1); chk_bus("R4 R6 bus edge 2", B0, 1'b1);
    at_bus(1); chk_bus("R6 bus edge 3", B0, 1'b1);
    bus_hold_n = 1'b1;
    at_bus(1); chk_bus("R5 bus edge 1", B0, 1'b1);
    at_bus(1); chk_bus("R5 bus edge 2", B1, 1'b1);
  endtask

  task automatic t_sleep;
    at_bus(1);
    sleep_n = 1'b0;
    fork
      begin
        at_core(2); chk_core("R7 core edge 2", C1);
        at_core(1); chk_core("R7 core edge 3", C0);
      end
      begin
        at_bus(2); chk_bus("R7 bus edge 2", B1, 1'b1);
        at_bus(1); chk_bus("R7 bus edge 3", B0, 1'b0);
      end
    join
    at_bus(3);
    chk_bus("R7 bus held", B0, 1'b0);
    sleep_n = 1'b1;
    fork
      begin
        at_core(2); chk_core("R8 core edge 2", C0);
        at_core(1); chk_core("R8 core edge 3", C1);
      end
      begin
        at_bus(2); chk_bus("R8 bus edge 2", B0, 1'b0);
        at_bus(1); chk_bus("R8 bus edge 3", B1, 1'b1);
      end
    join
  endtask

  task automatic t_priority;
    at_bus(1);
    sleep_n = 1'b0;
    at_bus(4);
    core_hold_n = 1'b0; bus_hold_n = 1'b0;
    at_core(3);
    core_hold_n = 1'b1; bus_hold_n = 1'b1;
    at_core(4); chk_core("R9 core stays asleep", C0);
    at_bus(2);  chk_bus("R9 bus stays asleep", B0, 1'b0);
    core_hold_n = 1'b0; bus_hold_n = 1'b0;
    at_bus(1);
    sleep_n = 1'b1;
    at_bus(4);  chk_bus("R9 only free bus resumes", B0, 1'b1);
    at_core(1); chk_core("R9 core held", C0);
    core_hold_n = 1'b1; bus_hold_n = 1'b1;
    at_bus(4);  chk_bus("R9 bus after hold release", B1, 1'b1);
    at_core(1); chk_core("R9 core after hold release", C1);
  endtask

  task automatic t_drive;
    at_core(1);
    mon_en = 1'b0;
    drive_en = 1'b0;
    #1;
    chk_core("R10 core released", CZ);
    chk_bus("R10 bus released", BZ, 1'bz);
    sleep_n = 1'b0;
    at_bus(4);
    chk_core("R10 core released in sleep", CZ);
    chk_bus("R10 bus released in sleep", BZ, 1'bz);
    sleep_n = 1'b1;
    at_bus(4);
    chk_bus("R10 bus still released", BZ, 1'bz);
    drive_en = 1'b1;
    #1;
    chk_bus("R10 bus driven again", B1, 1'b1);
    at_bus(1);
    #20;
    mon_en = 1'b1;
    at_core(1); chk_core("R10 core driven again", C1);
  endtask

  initial begin
    t_reset();
    t_core_hold();
    t_bus_hold();
    t_sleep();
    t_priority();
    t_drive();
    at_bus(4);
    n_vec++;
    if (runts != 0 || pulses == 0) begin
      n_bad++;
      $display("FAIL R11: actual %0d runt pulses of %0d expected 0 of >0", runts, pulses);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule